// File: doc/BRIEF.md
# Reconfigurable-Region Reset and Isolation Sequencer

This block orders the reset and isolation signals for a region of logic that is reloaded while the rest of the chip keeps running. The region mixes two kinds of sub-blocks. Some clear while an active-high level reset is held. Others clear themselves on a 0-to-1 transition of their reset and then run while that reset stays high. The sequencer keeps the region's boundary isolated from the moment the global write enable comes back. It holds the level reset until end-of-startup has risen. It then delivers a clean rising edge to the edge-sensitive logic before it reconnects the boundary.

Software arms the sequencer with a one-cycle start request and picks a mode at the same time. In split mode, a separate edge reset rises on the same clock edge on which the level reset falls, so every sub-block starts together. In shared mode, one reset serves both kinds of sub-block; the edge reset pin carries the same waveform as the level reset pin. After end-of-startup, that shared reset dips low for a programmable number of cycles, returns high for one cycle, then releases. In both modes a programmable settle window follows the release. The isolation enable drops only after that window, and a one-cycle completion pulse marks entry to normal operation. The global-write-enable and end-of-startup status inputs are asynchronous and pass through two-flop synchronizers. All pins are plain control and status levels; no streaming interface exists.

Top module: `rm_reset_seq`

## Requirements
- R1: After reset and in the idle state, the outputs are `lvl_rst`=1, `edge_rst`=0, `decouple`=1 and `done`=0. The idle state is left only when `start_req` is high at a clock edge; global-write-enable and end-of-startup activity alone has no effect there.
- R2: `decouple` stays 1 from the start request until the cycle in which the sequence enters normal operation, and it falls only at the end of the settle window.
- R3: `lvl_rst` stays 1 until a rising edge of `eos_in` has been observed. The outputs change three clock edges after `eos_in` rises: two for the synchronizer and one for the state register.
- R4: In split mode (`mode_single`=0), `edge_rst` is 0 while reset is held. It rises on the same clock edge on which `lvl_rst` falls, and stays 1 during normal operation.
- R5: In shared mode (`mode_single`=1), `edge_rst` equals `lvl_rst` from the hold phase onward. After end-of-startup both go low for `low_len` cycles (0 counts as 1). They then go high for exactly one cycle, and then go low again.
- R6: After the release, `decouple` stays 1 for `settle_len` cycles (0 counts as 1). Then `decouple` falls and `done` is 1 for exactly one cycle.
- R7: If global-write-enable falls while the sequence is between the hold phase and the settle window, the block returns to isolation with `lvl_rst`=1, `edge_rst`=0, `decouple`=1. If it falls during normal operation, the block returns to idle.
- R8: End-of-startup acts once per rising edge. A rising edge seen before global-write-enable arrives is kept pending and used. A level that simply stays high after an abort does not restart the sequence.
- R9: `mode_single` is sampled only together with an accepted `start_req`; changes at any other time have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| gwe_in | input | 1 | Global write enable status, asynchronous |
| eos_in | input | 1 | End-of-startup status, asynchronous |
| start_req | input | 1 | One-cycle request that arms a sequence |
| mode_single | input | 1 | 1 = one shared reset, 0 = split level and edge resets |
| low_len | input | CNT_W | Low-phase length of the shared-reset dip, in cycles |
| settle_len | input | CNT_W | Cycles between release and reconnecting the boundary |
| lvl_rst | output | 1 | Active-high level reset for the region |
| edge_rst | output | 1 | Reset for edge-sensitive sub-blocks |
| decouple | output | 1 | Isolation enable for the boundary logic |
| done | output | 1 | One-cycle pulse on entering normal operation |

## Verification
The bench compares every output in every cycle after end-of-startup against a waveform it computes from the mode and the two lengths, including zero lengths. A design that released the level reset one cycle away from the edge reset's rise, or stretched the one-cycle high of the shared dip, would show up as a mismatched sample. It also flips the mode pin right after arming, to catch a design that reads the mode late. Two further cases are covered. In one, global-write-enable and end-of-startup rise together; a design without a pending flag would wait forever in the hold phase. In the other, global-write-enable is withdrawn during the settle window while end-of-startup stays high. A level-triggered design would then release the region a second time without a new end-of-startup edge.

// File: rtl/rm_reset_seq_pkg.sv
package rm_reset_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ISOLATE    = 3'd1,
    ST_HOLD       = 3'd2,
    ST_PULSE_LOW  = 3'd3,
    ST_PULSE_HIGH = 3'd4,
    ST_RELEASE    = 3'd5,
    ST_RUN        = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic lvl;
    logic edg;
    logic dec;
  } rst_out_t;

  // Output levels for each state; shared mode mirrors the level reset.
  function automatic rst_out_t decode_out(seq_state_e s, logic single);
    rst_out_t o;
    o = '{lvl: 1'b1, edg: 1'b0, dec: 1'b1};
    unique case (s)
      ST_IDLE, ST_ISOLATE: o = '{lvl: 1'b1, edg: 1'b0,    dec: 1'b1};
      ST_HOLD:             o = '{lvl: 1'b1, edg: single,  dec: 1'b1};
      ST_PULSE_LOW:        o = '{lvl: 1'b0, edg: 1'b0,    dec: 1'b1};
      ST_PULSE_HIGH:       o = '{lvl: 1'b1, edg: 1'b1,    dec: 1'b1};
      ST_RELEASE:          o = '{lvl: 1'b0, edg: !single, dec: 1'b1};
      ST_RUN:              o = '{lvl: 1'b0, edg: !single, dec: 1'b0};
      default:             o = '{lvl: 1'b1, edg: 1'b0,    dec: 1'b1};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/rm_reset_seq_sync.sv
module rm_reset_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/rm_reset_seq_cnt.sv
module rm_reset_seq_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             en,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ld_val;

  // A length of zero behaves as one cycle.
  assign ld_val = (len == '0) ? '0 : len - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= ld_val;
    else if (en && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  a_r6_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && en && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rm_reset_seq_fsm.sv
module rm_reset_seq_fsm
  import rm_reset_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gwe_s,
  input  logic             eos_s,
  input  logic             start_req,
  input  logic             mode_single,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] settle_len,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_len,
  output logic             cnt_en,
  output logic             lvl_rst,
  output logic             edge_rst,
  output logic             decouple,
  output logic             done
);

  seq_state_e state, nxt;
  logic       mode_q;
  logic       eos_d;
  logic       eos_rise;
  logic       eos_pend;
  logic       eos_evt;
  logic       in_seq;
  logic       leave_hold;
  rst_out_t   out_nxt;

  assign eos_rise = eos_s & ~eos_d;
  assign eos_evt  = eos_rise | eos_pend;
  assign in_seq   = (state == ST_HOLD) || (state == ST_PULSE_LOW) ||
                    (state == ST_PULSE_HIGH) || (state == ST_RELEASE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:       if (start_req) nxt = ST_ISOLATE;
      ST_ISOLATE:    if (gwe_s) nxt = ST_HOLD;
      ST_HOLD:       if (eos_evt) nxt = mode_q ? ST_PULSE_LOW : ST_RELEASE;
      ST_PULSE_LOW:  if (cnt_zero) nxt = ST_PULSE_HIGH;
      ST_PULSE_HIGH: nxt = ST_RELEASE;
      ST_RELEASE:    if (cnt_zero) nxt = ST_RUN;
      ST_RUN:        if (!gwe_s) nxt = ST_IDLE;
      default:       nxt = ST_IDLE;
    endcase
    if (in_seq && !gwe_s) nxt = ST_ISOLATE;
  end

  assign leave_hold = (state == ST_HOLD) && (nxt != ST_HOLD);
  assign cnt_load   = ((nxt == ST_PULSE_LOW) && (state != ST_PULSE_LOW)) ||
                      ((nxt == ST_RELEASE) && (state != ST_RELEASE));
  assign cnt_len    = (nxt == ST_PULSE_LOW) ? low_len : settle_len;
  assign cnt_en     = (state == ST_PULSE_LOW) || (state == ST_RELEASE);
  assign out_nxt    = decode_out(nxt, mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= 1'b0;
      eos_d    <= 1'b0;
      eos_pend <= 1'b0;
      lvl_rst  <= 1'b1;
      edge_rst <= 1'b0;
      decouple <= 1'b1;
      done     <= 1'b0;
    end else begin
      state    <= nxt;
      eos_d    <= eos_s;
      if (state == ST_IDLE && start_req) mode_q <= mode_single;
      if (state == ST_IDLE || leave_hold) eos_pend <= 1'b0;
      else if (eos_rise)                  eos_pend <= 1'b1;
      lvl_rst  <= out_nxt.lvl;
      edge_rst <= out_nxt.edg;
      decouple <= out_nxt.dec;
      done     <= (nxt == ST_RUN) && (state != ST_RUN);
    end
  end

  // R3: reset held while no end-of-startup event is available
  a_r3_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !eos_evt) |=> lvl_rst);

  // R4: edge reset rises on the very edge that releases the level reset
  a_r4_edge_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && $fell(lvl_rst)) |-> $rose(edge_rst));

  // R5: shared mode keeps both pins identical once past isolation
  a_r5_shared_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && state != ST_IDLE && state != ST_ISOLATE) |-> (edge_rst == lvl_rst));

  // R2: boundary reconnects only out of the settle window
  a_r2_decouple_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(decouple) |-> ($past(state) == ST_RELEASE && state == ST_RUN));

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: withdrawal of write enable mid-sequence returns to isolation
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && !gwe_s) |=> (state == ST_ISOLATE && lvl_rst && !edge_rst && decouple));

endmodule

// File: rtl/rm_reset_seq.sv
module rm_reset_seq #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gwe_in,
  input  logic             eos_in,
  input  logic             start_req,
  input  logic             mode_single,
  input  logic [CNT_W-1:0] low_len,
  input  logic [CNT_W-1:0] settle_len,
  output logic             lvl_rst,
  output logic             edge_rst,
  output logic             decouple,
  output logic             done
);

  logic             gwe_s;
  logic             eos_s;
  logic             cnt_load;
  logic             cnt_en;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_len;

  rm_reset_seq_sync #(.STAGES(SYNC_STAGES)) u_sync_gwe (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (gwe_in),
    .sync_out (gwe_s)
  );

  rm_reset_seq_sync #(.STAGES(SYNC_STAGES)) u_sync_eos (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (eos_in),
    .sync_out (eos_s)
  );

  rm_reset_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cnt_load),
    .len   (cnt_len),
    .en    (cnt_en),
    .zero  (cnt_zero)
  );

  rm_reset_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .gwe_s       (gwe_s),
    .eos_s       (eos_s),
    .start_req   (start_req),
    .mode_single (mode_single),
    .low_len     (low_len),
    .settle_len  (settle_len),
    .cnt_zero    (cnt_zero),
    .cnt_load    (cnt_load),
    .cnt_len     (cnt_len),
    .cnt_en      (cnt_en),
    .lvl_rst     (lvl_rst),
    .edge_rst    (edge_rst),
    .decouple    (decouple),
    .done        (done)
  );

endmodule

// File: tb/rm_reset_seq_bench.sv
module rm_reset_seq_bench;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             gwe_in = 1'b0;
  logic             eos_in = 1'b0;
  logic             start_req = 1'b0;
  logic             mode_single = 1'b0;
  logic [CNT_W-1:0] low_len = '0;
  logic [CNT_W-1:0] settle_len = '0;
  logic             lvl_rst, edge_rst, decouple, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rm_reset_seq #(.CNT_W(CNT_W)) u_rm_reset_seq (
    .clk(clk), .rst_n(rst_n), .gwe_in(gwe_in), .eos_in(eos_in),
    .start_req(start_req), .mode_single(mode_single),
    .low_len(low_len), .settle_len(settle_len),
    .lvl_rst(lvl_rst), .edge_rst(edge_rst), .decouple(decouple), .done(done)
  );

  // {mode, low_len, settle_len}
  localparam logic [16:0] VECS [7] = '{
    {1'b0, 8'd0, 8'd1},
    {1'b0, 8'd2, 8'd4},
    {1'b1, 8'd1, 8'd1},
    {1'b1, 8'd3, 8'd2},
    {1'b1, 8'd0, 8'd0},
    {1'b0, 8'd5, 8'd0},
    {1'b1, 8'd6, 8'd3}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {lvl_rst, edge_rst, decouple, done};
  endfunction

  // Expected {lvl, edge, dec, done} at the k-th sample after eos rises.
  function automatic logic [3:0] exp_wave(int k, bit m, int le, int se);
    if (!m) begin
      if (k < 3)       return 4'b1010;
      if (k < 3 + se)  return 4'b0110;
      if (k == 3 + se) return 4'b0101;
      return 4'b0100;
    end
    if (k < 3)            return 4'b1110;
    if (k < 3 + le)       return 4'b0010;
    if (k == 3 + le)      return 4'b1110;
    if (k < 4 + le + se)  return 4'b0010;
    if (k == 4 + le + se) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic arm(bit m);
    mode_single = m;
    start_req = 1'b1;
    tick(1);
    start_req = 1'b0;
    mode_single = !m;  // R9: later changes must be ignored
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 outputs during reset", outs(), 4'b1010);
    rst_n = 1'b1;
    tick(2);
    chk("R1 idle outputs after reset", outs(), 4'b1010);

    // R1: status activity without start leaves the block idle
    gwe_in = 1'b1;
    tick(4);
    eos_in = 1'b1;
    tick(10);
    chk("R1 no start, stays idle", outs(), 4'b1010);
    gwe_in = 1'b0;
    eos_in = 1'b0;
    tick(4);

    // Vector walk: every sample after end-of-startup is compared.
    for (int v = 0; v < 7; v++) begin
      bit m;
      int le, se;
      m  = VECS[v][16];
      le = (VECS[v][15:8] == 0) ? 1 : int'(VECS[v][15:8]);
      se = (VECS[v][7:0] == 0) ? 1 : int'(VECS[v][7:0]);
      low_len    = VECS[v][15:8];
      settle_len = VECS[v][7:0];
      arm(m);
      tick(3);
      chk("R2 isolation after start", outs(), 4'b1010);
      gwe_in = 1'b1;
      tick(4);
      chk(m ? "R5 hold phase shared" : "R3 hold phase split", outs(),
          m ? 4'b1110 : 4'b1010);
      eos_in = 1'b1;
      for (int k = 1; k <= le + se + 6; k++) begin
        tick(1);
        chk(m ? "R5/R6/R9 shared waveform" : "R4/R6/R9 split waveform",
            outs(), exp_wave(k, m, le, se));
      end
      gwe_in = 1'b0;
      eos_in = 1'b0;
      tick(4);
      chk("R7 run to idle on write-enable loss", outs(), 4'b1010);
      // Idle, not isolation: a fresh eos edge alone must not release.
      gwe_in = 1'b1;
      tick(4);
      eos_in = 1'b1;
      tick(6);
      chk("R1 idle ignores status after run", outs(), 4'b1010);
      gwe_in = 1'b0;
      eos_in = 1'b0;
      tick(4);
    end

    // R8: write enable and eos rise together; edge kept pending.
    begin
      bit seen;
      seen = 1'b0;
      low_len = 8'd2;
      settle_len = 8'd2;
      arm(1'b0);
      tick(2);
      gwe_in = 1'b1;
      eos_in = 1'b1;
      for (int i = 0; i < 30; i++) begin
        tick(1);
        if (done) seen = 1'b1;
      end
      chk("R8 pending eos completes sequence", {seen, outs()}, 5'b10100);
      gwe_in = 1'b0;
      eos_in = 1'b0;
      tick(4);
    end

    // R7 and R8: abort during settle, then a held eos must not restart.
    begin
      bit seen;
      seen = 1'b0;
      settle_len = 8'd20;
      arm(1'b0);
      tick(2);
      gwe_in = 1'b1;
      tick(4);
      eos_in = 1'b1;
      tick(5);
      chk("R4 released during settle", outs(), 4'b0110);
      gwe_in = 1'b0;
      tick(3);
      chk("R7 abort returns to isolation", outs(), 4'b1010);
      gwe_in = 1'b1;
      for (int i = 0; i < 30; i++) begin
        tick(1);
        if (done || !lvl_rst) seen = 1'b1;
      end
      chk("R8 held eos does not restart", {seen, outs()}, 5'b01010);
      eos_in = 1'b0;
      tick(4);
      eos_in = 1'b1;
      settle_len = 8'd1;
      tick(3);
      chk("R4 fresh eos edge releases", outs(), 4'b0110);
      tick(1);
      chk("R6 done after fresh release", outs(), 4'b0101);
      tick(1);
      chk("R6 done lasts one cycle", outs(), 4'b0100);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule